// File: doc/BRIEF.md
# Bouncing Square Animator

This block paints a solid square that drifts diagonally across a raster display and rebounds off all four screen edges. It sits after the display timing generator. Each pixel clock it receives the current beam coordinates and the data-enable flag, and it returns a 4-bit red, green and blue value for that pixel. The square moves once per frame, or once every few frames when slowed down. The step happens when the beam enters vertical blanking.

Each axis keeps its own position and direction. When a step would carry the square past the far edge, the square is placed flush against that edge and turns around, whatever its speed. The near-edge test compares the position with the speed in unsigned arithmetic, so a negative position is never computed. Every reversal moves the fill colour on to the next entry of an eight-colour table. A frame in which both axes reverse counts as one reversal.

Top module: `bounce_square`

## Requirements
- R1: A position step happens only on a clock where `sy` equals V_RES (480) and `sx` equals 0. The new position is visible in the paint output from the next clock.
- R2: With SLOW = N, only the 1st, (N+1)th, (2N+1)th ... step pulse after reset moves the square. The other pulses leave it where it is.
- R3: Direction 0 means right on the x axis and down on the y axis. A normal step adds SPEED (2) to the position on each axis while that axis moves in direction 0, and subtracts SPEED on each axis while it moves in direction 1.
- R4: In direction 0, if position + SIZE + SPEED ≥ RES − 1, the position becomes RES − SIZE − 1 (439 for x, 279 for y) and the direction becomes 1. RES is 640 for x and 480 for y.
- R5: On clocks that are not step pulses, position, direction and colour index keep their values.
- R6: In direction 1, if position < SPEED, the position becomes 0 and the direction becomes 0.
- R7: A pixel is inside when qx ≤ sx < qx + SIZE and qy ≤ sy < qy + SIZE, with SIZE 200. A pixel outside the square is painted background 0x137 (r = 1, g = 3, b = 7).
- R8: Inside pixels take the fill colour at a 3-bit index. The table, from index 0 to 7, is 0xFFF, 0xFC0, 0xF6A, 0x6FF, 0xFF4, 0xC8F, 0x4F6, 0xF84. The index rises by one, wrapping modulo 8, on every step in which at least one axis reverses, and by no more than one per step.
- R9: While `de` is low, all three paint outputs are 0.
- R10: Reset puts the square at (0,0), moving right and down, with colour index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sx | input | CORDW (10) | Horizontal beam coordinate |
| sy | input | CORDW (10) | Vertical beam coordinate |
| de | input | 1 | High during the active picture area |
| paint_r | output | 4 | Red level |
| paint_g | output | 4 | Green level |
| paint_b | output | 4 | Blue level |

## Verification
The assertions assume that `sx` and `sy` come from a timing generator. In particular, the step coordinate (sx = 0, sy = V_RES) appears for a single clock at a time, so that each step is a separate event. The bench does not sweep a full raster. It jumps straight to that coordinate for one clock per frame, then to a few probe pixels chosen around the square's expected corners and edges, and now and then to other blanking coordinates that must not cause a step. Two copies of the block, one at full speed and one slowed by three, receive the same stimulus and are compared every clock against behavioural models.

// File: rtl/sq_pkg.sv
package sq_pkg;

    typedef enum logic {
        DIR_FWD  = 1'b0,
        DIR_BACK = 1'b1
    } dir_t;

    typedef struct packed {
        logic [3:0] r;
        logic [3:0] g;
        logic [3:0] b;
    } rgb_t;

    localparam int   IDX_W   = 3;
    localparam rgb_t BG_RGB  = '{r: 4'h1, g: 4'h3, b: 4'h7};
    localparam rgb_t OFF_RGB = '{r: 4'h0, g: 4'h0, b: 4'h0};

    function automatic rgb_t fill_colour(input logic [IDX_W-1:0] idx);
        rgb_t c;
        case (idx)
            3'd0:    c = '{r: 4'hF, g: 4'hF, b: 4'hF};
            3'd1:    c = '{r: 4'hF, g: 4'hC, b: 4'h0};
            3'd2:    c = '{r: 4'hF, g: 4'h6, b: 4'hA};
            3'd3:    c = '{r: 4'h6, g: 4'hF, b: 4'hF};
            3'd4:    c = '{r: 4'hF, g: 4'hF, b: 4'h4};
            3'd5:    c = '{r: 4'hC, g: 4'h8, b: 4'hF};
            3'd6:    c = '{r: 4'h4, g: 4'hF, b: 4'h6};
            default: c = '{r: 4'hF, g: 4'h8, b: 4'h4};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sq_frame_tick.sv
module sq_frame_tick #(
    parameter int CORDW = 10,
    parameter int V_RES = 480,
    parameter int SLOW  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CORDW-1:0] sx,
    input  logic [CORDW-1:0] sy,
    output logic             step
);
    localparam int CW = $clog2(SLOW) + 1;

    logic          frame;
    logic [CW-1:0] slow_cnt;

    // Beam enters vertical blanking at the first pixel of line V_RES.
    always_comb frame = (sy == CORDW'(V_RES)) && (sx == '0);
    always_comb step  = frame && (slow_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            slow_cnt <= '0;
        end else if (frame) begin
            slow_cnt <= (slow_cnt == CW'(SLOW - 1)) ? '0 : slow_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sq_axis.sv
module sq_axis
    import sq_pkg::*;
#(
    parameter int CORDW = 10,
    parameter int RES   = 640,
    parameter int SIZE  = 200,
    parameter int SPEED = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [CORDW-1:0] pos,
    output dir_t             dir,
    output logic             flip
);
    localparam int SW      = CORDW + 2;
    localparam int FAR_POS = RES - SIZE - 1;

    logic [SW-1:0] lead_edge;
    logic          hit_far;
    logic          hit_near;

    // Leading edge after the next step, in a width that cannot wrap.
    always_comb begin
        lead_edge = SW'(pos) + SW'(SIZE + SPEED);
        hit_far   = (dir == DIR_FWD)  && (lead_edge >= SW'(RES - 1));
        hit_near  = (dir == DIR_BACK) && (pos < CORDW'(SPEED));
        flip      = step && (hit_far || hit_near);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
            dir <= DIR_FWD;
        end else if (step) begin
            if (hit_far) begin
                pos <= CORDW'(FAR_POS);
                dir <= DIR_BACK;
            end else if (hit_near) begin
                pos <= '0;
                dir <= DIR_FWD;
            end else if (dir == DIR_FWD) begin
                pos <= pos + CORDW'(SPEED);
            end else begin
                pos <= pos - CORDW'(SPEED);
            end
        end
    end

endmodule

// File: rtl/sq_palette.sv
module sq_palette
    import sq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flip_x,
    input  logic             flip_y,
    output logic [IDX_W-1:0] idx,
    output rgb_t             fill
);
    // A simultaneous corner hit counts as a single bounce.
    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (flip_x || flip_y) begin
            idx <= idx + 1'b1;
        end
    end

    always_comb fill = fill_colour(idx);

endmodule

// File: rtl/sq_paint.sv
module sq_paint
    import sq_pkg::*;
#(
    parameter int CORDW = 10,
    parameter int SIZE  = 200
) (
    input  logic [CORDW-1:0] sx,
    input  logic [CORDW-1:0] sy,
    input  logic             de,
    input  logic [CORDW-1:0] qx,
    input  logic [CORDW-1:0] qy,
    input  rgb_t             fill,
    output rgb_t             pix
);
    localparam int SW = CORDW + 1;

    logic in_x, in_y;

    always_comb begin
        in_x = (sx >= qx) && (SW'(sx) < SW'(qx) + SW'(SIZE));
        in_y = (sy >= qy) && (SW'(sy) < SW'(qy) + SW'(SIZE));
        if (!de)
            pix = OFF_RGB;
        else if (in_x && in_y)
            pix = fill;
        else
            pix = BG_RGB;
    end

endmodule

// File: rtl/bounce_square.sv
module bounce_square
    import sq_pkg::*;
#(
    parameter int CORDW = 10,
    parameter int H_RES = 640,
    parameter int V_RES = 480,
    parameter int SIZE  = 200,
    parameter int SPEED = 2,
    parameter int SLOW  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CORDW-1:0] sx,
    input  logic [CORDW-1:0] sy,
    input  logic             de,
    output logic [3:0]       paint_r,
    output logic [3:0]       paint_g,
    output logic [3:0]       paint_b
);
    logic             frame_step;
    logic [CORDW-1:0] pos_x, pos_y;
    dir_t             dir_x, dir_y;
    logic             flip_x, flip_y;
    logic [IDX_W-1:0] colour_idx;
    rgb_t             fill_rgb;
    rgb_t             pix_rgb;

    sq_frame_tick #(
        .CORDW(CORDW), .V_RES(V_RES), .SLOW(SLOW)
    ) u_tick (
        .clk(clk), .rst(rst), .sx(sx), .sy(sy), .step(frame_step)
    );

    sq_axis #(
        .CORDW(CORDW), .RES(H_RES), .SIZE(SIZE), .SPEED(SPEED)
    ) u_axis_x (
        .clk(clk), .rst(rst), .step(frame_step),
        .pos(pos_x), .dir(dir_x), .flip(flip_x)
    );

    sq_axis #(
        .CORDW(CORDW), .RES(V_RES), .SIZE(SIZE), .SPEED(SPEED)
    ) u_axis_y (
        .clk(clk), .rst(rst), .step(frame_step),
        .pos(pos_y), .dir(dir_y), .flip(flip_y)
    );

    sq_palette u_pal (
        .clk(clk), .rst(rst), .flip_x(flip_x), .flip_y(flip_y),
        .idx(colour_idx), .fill(fill_rgb)
    );

    sq_paint #(
        .CORDW(CORDW), .SIZE(SIZE)
    ) u_paint (
        .sx(sx), .sy(sy), .de(de), .qx(pos_x), .qy(pos_y),
        .fill(fill_rgb), .pix(pix_rgb)
    );

    always_comb begin
        paint_r = pix_rgb.r;
        paint_g = pix_rgb.g;
        paint_b = pix_rgb.b;
    end

endmodule

// File: rtl/bounce_square_chk.sv
module bounce_square_chk
    import sq_pkg::*;
#(
    parameter int CORDW = 10,
    parameter int H_RES = 640,
    parameter int V_RES = 480,
    parameter int SIZE  = 200
) (
    input logic             clk,
    input logic             rst,
    input logic             step,
    input logic [CORDW-1:0] qx,
    input logic [CORDW-1:0] qy,
    input dir_t             dirx,
    input dir_t             diry,
    input logic [IDX_W-1:0] cidx,
    input logic             de,
    input logic [3:0]       pr,
    input logic [3:0]       pg,
    input logic [3:0]       pb
);
    // R4
    pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        (qx <= CORDW'(H_RES - SIZE - 1)) && (qy <= CORDW'(V_RES - SIZE - 1)));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(qx) && $stable(qy) && $stable(dirx) && $stable(diry) && $stable(cidx)));

    // R4
    far_clamp_x_chk: assert property (@(posedge clk) disable iff (rst)
        (dirx == DIR_BACK && $past(dirx) == DIR_FWD) |-> qx == CORDW'(H_RES - SIZE - 1));

    // R4
    far_clamp_y_chk: assert property (@(posedge clk) disable iff (rst)
        (diry == DIR_BACK && $past(diry) == DIR_FWD) |-> qy == CORDW'(V_RES - SIZE - 1));

    // R6
    near_clamp_x_chk: assert property (@(posedge clk) disable iff (rst)
        (dirx == DIR_FWD && $past(dirx) == DIR_BACK) |-> qx == '0);

    // R6
    near_clamp_y_chk: assert property (@(posedge clk) disable iff (rst)
        (diry == DIR_FWD && $past(diry) == DIR_BACK) |-> qy == '0);

    // R8
    colour_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cidx == $past(cidx)) || (cidx == $past(cidx) + 3'd1));

    // R9
    blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
        !de |-> (pr == 4'h0 && pg == 4'h0 && pb == 4'h0));

endmodule

bind bounce_square bounce_square_chk #(
    .CORDW(CORDW), .H_RES(H_RES), .V_RES(V_RES), .SIZE(SIZE)
) u_chk (
    .clk(clk), .rst(rst), .step(frame_step),
    .qx(pos_x), .qy(pos_y), .dirx(dir_x), .diry(dir_y),
    .cidx(colour_idx), .de(de),
    .pr(paint_r), .pg(paint_g), .pb(paint_b)
);

// File: tb/test_bounce_square.sv
`timescale 1ns/1ps

module bounce_ref #(
    parameter int SLOW = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [9:0] sx,
    input  logic [9:0] sy,
    input  logic       de,
    output logic [11:0] exp_rgb,
    output int         mx,
    output int         my,
    output int         evt
);
    int dx, dy, ci, cnt;

    function automatic logic [11:0] table_colour(input int i);
        case (i)
            0: return 12'hFFF;
            1: return 12'hFC0;
            2: return 12'hF6A;
            3: return 12'h6FF;
            4: return 12'hFF4;
            5: return 12'hC8F;
            6: return 12'h4F6;
            default: return 12'hF84;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mx = 0; my = 0; dx = 0; dy = 0; ci = 0; cnt = 0; evt = 0;
        end else if (sy == 10'd480 && sx == 10'd0) begin
            if (cnt == 0) begin
                int f;
                f = 0; evt = 0;
                if (dx == 0) begin
                    if (mx + 202 >= 639) begin mx = 439; dx = 1; f = 1; evt = 1; end
                    else mx = mx + 2;
                end else begin
                    if (mx < 2) begin mx = 0; dx = 0; f = 1; evt = 2; end
                    else mx = mx - 2;
                end
                if (dy == 0) begin
                    if (my + 202 >= 479) begin my = 279; dy = 1; f = 1; evt = 1; end
                    else my = my + 2;
                end else begin
                    if (my < 2) begin my = 0; dy = 0; f = 1; evt = 2; end
                    else my = my - 2;
                end
                if (f != 0) ci = (ci + 1) % 8;
            end
            cnt = (cnt + 1) % SLOW;
        end
    end

    always_comb begin
        if (!de)
            exp_rgb = 12'h000;
        else if (int'(sx) >= mx && int'(sx) < mx + 200 && int'(sy) >= my && int'(sy) < my + 200)
            exp_rgb = table_colour(ci);
        else
            exp_rgb = 12'h137;
    end
endmodule

module test_bounce_square;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] sx = '0;
    logic [9:0] sy = '0;
    logic       de = 1'b1;
    logic [3:0] r0, g0, b0, r1, g1, b1;
    logic [11:0] e0, e1;
    int mx0, my0, ev0, mx1, my1, ev1;
    int checks = 0;
    int errors = 0;
    string tag = "R10";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bounce_square i_bounce_square (
        .clk(clk), .rst(rst), .sx(sx), .sy(sy), .de(de),
        .paint_r(r0), .paint_g(g0), .paint_b(b0)
    );

    bounce_square #(.SLOW(3)) i_bounce_square_slow (
        .clk(clk), .rst(rst), .sx(sx), .sy(sy), .de(de),
        .paint_r(r1), .paint_g(g1), .paint_b(b1)
    );

    bounce_ref #(.SLOW(1)) u_ref0 (.clk(clk), .rst(rst), .sx(sx), .sy(sy), .de(de),
        .exp_rgb(e0), .mx(mx0), .my(my0), .evt(ev0));
    bounce_ref #(.SLOW(3)) u_ref1 (.clk(clk), .rst(rst), .sx(sx), .sy(sy), .de(de),
        .exp_rgb(e1), .mx(mx1), .my(my1), .evt(ev1));

    // Compare both copies every clock, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if ({r0, g0, b0} !== e0) begin
                errors++;
                $display("FAIL %s: sx=%0d sy=%0d de=%0b got %h expected %h",
                         tag, sx, sy, de, {r0, g0, b0}, e0);
            end
            checks++;
            if ({r1, g1, b1} !== e1) begin
                errors++;
                $display("FAIL R2 (slowed copy, %s): sx=%0d sy=%0d got %h expected %h",
                         tag, sx, sy, {r1, g1, b1}, e1);
            end
        end
    end

    task automatic drive(input int x, input int y, input bit en, input string t);
        tag = t;
        sx  = 10'(x);
        sy  = 10'(y);
        de  = en;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: white square at the origin right after reset
        drive(0, 0, 1'b1, "R10");
        drive(199, 199, 1'b1, "R10");
        drive(200, 0, 1'b1, "R7");
        drive(5, 5, 1'b0, "R9");
        for (int fr = 0; fr < 1300; fr++) begin
            string mt;
            // R1: the step coordinate, inside vertical blanking
            drive(0, 480, 1'b0, "R1");
            mt = (ev0 == 1) ? "R4" : (ev0 == 2) ? "R6" : "R3";
            drive(mx0, my0, 1'b1, mt);
            drive(mx0 + 199, my0 + 199, 1'b1, "R8");
            drive(mx0 + 200, my0, 1'b1, "R7");
            drive(mx0, my0 + 200, 1'b1, "R7");
            if (mx0 > 0) drive(mx0 - 1, my0 + 10, 1'b1, "R7");
            if (my0 > 0) drive(mx0 + 10, my0 - 1, 1'b1, "R7");
            drive(mx0 + 50, my0 + 50, 1'b0, "R9");
            if (fr % 7 == 0) begin
                // R5: other blanking coordinates must not step
                drive(1, 480, 1'b0, "R5");
                drive(0, 481, 1'b0, "R5");
                drive(mx0, my0, 1'b1, "R5");
                drive(mx0 + 199, my0, 1'b1, "R5");
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule